// File: doc/BRIEF.md
# Quadrature-Phase Time-to-Digital Converter with Per-Channel Hit Store

This block timestamps rising edges on a bank of discriminator outputs. It runs from two copies of the main timing clock that are a quarter period apart. The main clock is the 0-degree copy, nominally 100 MHz from a 25 MHz reference multiplied by four. Each discriminator is sampled on the rising and falling edge of both clocks, which gives four equally spaced samples per clock period. The four samples are brought into the 0-degree domain as one window. The first sample in that window to see the signal high supplies a 2-bit fine code. A 14-bit coarse counter counts clock periods from the moment the spill gate opens, so one timestamp unit is a quarter of the clock period (2.5 ns at 100 MHz).

An external gate, sampled on the 0-degree clock, defines the acquisition interval. Each time it opens, every channel's store is emptied. While it stays open, each channel keeps its first four hits in arrival order. Once the gate has closed, a combinational read port selects a channel and a slot and returns the stored timestamp, a valid flag and the channel's hit count. This readout must happen before the gate opens again.

Top module: `multiphase_tdc`

## Requirements
- R1: After reset every channel reports a hit count of 0, and the valid flag is 0 for every slot.
- R2: A stored timestamp is `{coarse[13:0], fine[1:0]}`. Coarse is the number of 0-degree clock periods between the gate-open edge and the start of the window that holds the hit. Fine is 0, 1, 2 or 3 when the first high sample of that window was taken at the 0-degree rising, 90-degree rising, 0-degree falling or 90-degree falling edge respectively. The full value is the rise time, rounded up to the next sample instant and counted in quarter periods from the gate-open edge.
- R3: A hit is recorded only when the signal goes from low to high: the last sample of the previous window is 0 and at least one sample of the current window is 1. A level that stays high, including one already high when the gate opens, records no further hits.
- R4: Only windows that begin at a 0-degree rising edge where the gate is sampled high can record hits. Edges before the gate opens or after it closes are dropped.
- R5: Each channel keeps at most four hits, in arrival order in slots 0 to 3. Further hits in the same gate are discarded and the count stays at 4.
- R6: The read port returns, for `rd_chan` and `rd_idx`, the stored timestamp, `rd_valid` = 1 exactly when `rd_idx` is below the channel's count, and the channel's count (0 to 4).
- R7: A gate-open edge (gate sampled high after being sampled low) empties every channel. If a hit from the previous gate's last window is due to be written in that same cycle, the clear wins and the hit is lost.
- R8: Channels are independent: each channel's hits, count and timestamps depend only on its own discriminator input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk0 | input | 1 | Timing clock, 0-degree copy; all state and the read port belong to it |
| clk90 | input | 1 | Same clock shifted by a quarter period |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gate | input | 1 | Spill gate, synchronous to clk0 |
| disc | input | NCH | Discriminator latch outputs, one per channel |
| rd_chan | input | CH_W | Channel to read |
| rd_idx | input | IDX_W | Hit slot to read |
| rd_ts | output | TS_W | Stored timestamp of the selected slot (0 when not valid) |
| rd_valid | output | 1 | Selected slot holds a hit |
| rd_count | output | CNT_W | Number of hits stored for the selected channel |

## Verification
Two functions can act in the same clk0 cycle: the write of a hit from the last open window of one gate, and the clear caused by the next gate opening. The bench closes the gate for exactly one cycle, places a discriminator edge in the final open window, and reopens the gate. The clear then lands on the cycle of that pending write. The check requires that channel to read back empty, while a hit placed in the new gate is stored with a timestamp counted from the new opening edge.

// File: rtl/tdc_pkg.sv
`timescale 1ns/1ps
package tdc_pkg;
  // four sub-phases per clock period from the quadrature pair
  localparam int PHASES = 4;
  localparam int FINE_W = 2;

  typedef logic [PHASES-1:0] phase_vec_t;
  typedef logic [FINE_W-1:0] fine_t;

  // index of the earliest sample that reads high (0 when none)
  function automatic fine_t first_phase(input phase_vec_t v);
    fine_t r;
    r = '0;
    for (int i = PHASES - 1; i >= 0; i--) begin
      if (v[i]) r = fine_t'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/tdc_phase_sampler.sv
`timescale 1ns/1ps
module tdc_phase_sampler
  import tdc_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk0,
  input  logic              clk90,
  input  logic              rst_n,
  input  logic [NCH-1:0]    disc,
  output logic [NCH-1:0]    hit,
  output fine_t [NCH-1:0]   fine
);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic       s000, s090, s180, s270;
    phase_vec_t win_q, win_d;
    logic       last_q, last_d;

    always_ff @(posedge clk0 or negedge rst_n)
      if (!rst_n) s000 <= 1'b0; else s000 <= disc[g];
    always_ff @(posedge clk90 or negedge rst_n)
      if (!rst_n) s090 <= 1'b0; else s090 <= disc[g];
    always_ff @(negedge clk0 or negedge rst_n)
      if (!rst_n) s180 <= 1'b0; else s180 <= disc[g];
    always_ff @(negedge clk90 or negedge rst_n)
      if (!rst_n) s270 <= 1'b0; else s270 <= disc[g];

    // samples of the period that just ended, earliest in bit 0
    always_comb begin
      win_d  = {s270, s180, s090, s000};
      last_d = win_q[PHASES-1];
    end

    always_ff @(posedge clk0 or negedge rst_n) begin
      if (!rst_n) begin
        win_q  <= '0;
        last_q <= 1'b0;
      end else begin
        win_q  <= win_d;
        last_q <= last_d;
      end
    end

    assign hit[g]  = ~last_q & (|win_q);
    assign fine[g] = first_phase(win_q);
  end

endmodule

// File: rtl/tdc_timebase.sv
`timescale 1ns/1ps
module tdc_timebase #(
  parameter int COARSE_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gate,
  output logic                clr,
  output logic                win_open,
  output logic [COARSE_W-1:0] win_coarse
);

  logic                open_w_q, open_w_d;
  logic                open_d_q, open_d_d;
  logic [COARSE_W-1:0] cw_q, cw_d;
  logic [COARSE_W-1:0] cd_q, cd_d;
  logic                start;

  // stage w describes the window starting now; stage d the one under decode
  always_comb begin
    start    = gate & ~open_w_q;
    open_w_d = gate;
    cw_d     = cw_q;
    if (start)     cw_d = '0;
    else if (gate) cw_d = cw_q + 1'b1;
    open_d_d = open_w_q;
    cd_d     = cw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_w_q <= 1'b0;
      open_d_q <= 1'b0;
      cw_q     <= '0;
      cd_q     <= '0;
    end else begin
      open_w_q <= open_w_d;
      open_d_q <= open_d_d;
      cw_q     <= cw_d;
      cd_q     <= cd_d;
    end
  end

  assign clr        = start;
  assign win_open   = open_d_q;
  assign win_coarse = cd_q;

endmodule

// File: rtl/tdc_hit_buffer.sv
`timescale 1ns/1ps
module tdc_hit_buffer #(
  parameter int DEPTH = 4,
  parameter int TS_W  = 16,
  parameter int IDX_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [TS_W-1:0]  wr_ts,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TS_W-1:0]  rd_ts,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [DEPTH-1:0][TS_W-1:0] mem_q, mem_d;
  logic [CNT_W-1:0]           cnt_q, cnt_d;
  logic                       take;

  always_comb begin
    take  = wr_en & ~clr & (cnt_q < FULL);
    mem_d = mem_q;
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (take) begin
      cnt_d = cnt_q + 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
        if (cnt_q == CNT_W'(i)) mem_d[i] = wr_ts;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
      cnt_q <= '0;
    end else begin
      if (take) mem_q <= mem_d;
      cnt_q <= cnt_d;
    end
  end

  assign rd_ts = mem_q[rd_idx];
  assign count = cnt_q;

endmodule

// File: rtl/multiphase_tdc.sv
`timescale 1ns/1ps
module multiphase_tdc
  import tdc_pkg::*;
#(
  parameter int  NCH      = 4,
  parameter int  DEPTH    = 4,
  parameter int  COARSE_W = 14,
  localparam int TS_W     = COARSE_W + FINE_W,
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int CH_W     = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk0,
  input  logic             clk90,
  input  logic             rst_n,
  input  logic             gate,
  input  logic [NCH-1:0]   disc,
  input  logic [CH_W-1:0]  rd_chan,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TS_W-1:0]  rd_ts,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_count
);

  logic [1:0]                 rs_q;
  logic                       rst_sync_n;
  logic [NCH-1:0]             hit;
  fine_t [NCH-1:0]            fine;
  logic                       clr;
  logic                       win_open;
  logic [COARSE_W-1:0]        win_coarse;
  logic [NCH-1:0][TS_W-1:0]   ts_all;
  logic [NCH-1:0][CNT_W-1:0]  counts;
  logic [TS_W-1:0]            sel_ts;
  logic [CNT_W-1:0]           sel_cnt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk0 or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  tdc_phase_sampler #(.NCH(NCH)) u_sampler (
    .clk0 (clk0),
    .clk90(clk90),
    .rst_n(rst_sync_n),
    .disc (disc),
    .hit  (hit),
    .fine (fine)
  );

  tdc_timebase #(.COARSE_W(COARSE_W)) u_timebase (
    .clk       (clk0),
    .rst_n     (rst_sync_n),
    .gate      (gate),
    .clr       (clr),
    .win_open  (win_open),
    .win_coarse(win_coarse)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_buf
    tdc_hit_buffer #(
      .DEPTH(DEPTH), .TS_W(TS_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_buf (
      .clk   (clk0),
      .rst_n (rst_sync_n),
      .clr   (clr),
      .wr_en (hit[g] & win_open),
      .wr_ts ({win_coarse, fine[g]}),
      .rd_idx(rd_idx),
      .rd_ts (ts_all[g]),
      .count (counts[g])
    );
  end

  always_comb begin
    sel_ts  = '0;
    sel_cnt = '0;
    for (int c = 0; c < NCH; c++) begin
      if (rd_chan == CH_W'(c)) begin
        sel_ts  = ts_all[c];
        sel_cnt = counts[c];
      end
    end
  end

  assign rd_valid = CNT_W'(rd_idx) < sel_cnt;
  assign rd_ts    = rd_valid ? sel_ts : '0;
  assign rd_count = sel_cnt;

endmodule

// File: rtl/tdc_checker.sv
`timescale 1ns/1ps
module tdc_checker #(
  parameter int NCH   = 4,
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      clr,
  input logic                      win_open,
  input logic [NCH-1:0]            hit,
  input logic [NCH-1:0][CNT_W-1:0] counts
);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      counts[g] <= CNT_W'(DEPTH));

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (counts[g] != $past(counts[g])) |->
        (counts[g] == '0 || counts[g] == $past(counts[g]) + 1'b1));

    assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (counts[g] == '0));

    assert_grow_needs_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (counts[g] != $past(counts[g]) && counts[g] != '0) |-> $past(hit[g]));

    assert_grow_needs_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (counts[g] != $past(counts[g]) && counts[g] != '0) |-> $past(win_open));
  end

endmodule

bind multiphase_tdc tdc_checker #(
  .NCH(NCH), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_tdc_checker (
  .clk     (clk0),
  .rst_n   (rst_sync_n),
  .clr     (clr),
  .win_open(win_open),
  .hit     (hit),
  .counts  (counts)
);

// File: tb/multiphase_tdc_bench.sv
`timescale 1ns/1ps
module multiphase_tdc_bench;
  localparam int NCH   = 4;
  localparam int DEPTH = 4;
  localparam int MAXP  = 6;
  localparam int NEVER = 1 << 30;

  logic           clk0, clk90, rst_n, gate;
  logic [NCH-1:0] disc;
  logic [1:0]     rd_chan, rd_idx;
  logic [15:0]    rd_ts;
  logic           rd_valid;
  logic [2:0]     rd_count;

  int n_chk, n_fail;
  int pr[NCH][MAXP];
  int pw[NCH][MAXP];
  int pn[NCH];
  int e_ts[NCH][DEPTH];
  int e_n[NCH];
  int g_on1, g_off1, g_on2, g_off2;

  multiphase_tdc u_multiphase_tdc (
    .clk0(clk0), .clk90(clk90), .rst_n(rst_n), .gate(gate), .disc(disc),
    .rd_chan(rd_chan), .rd_idx(rd_idx), .rd_ts(rd_ts),
    .rd_valid(rd_valid), .rd_count(rd_count)
  );

  // 250 MHz pair, second copy a quarter period later
  initial begin clk0 = 1'b0; forever #2 clk0 = ~clk0; end
  initial begin clk90 = 1'b0; #1; forever #2 clk90 = ~clk90; end

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic plan_clear();
    for (int c = 0; c < NCH; c++) begin pn[c] = 0; e_n[c] = 0; end
    g_on2 = NEVER; g_off2 = NEVER;
  endtask

  task automatic add_pulse(int c, int h, int w);
    pr[c][pn[c]] = h; pw[c][pn[c]] = w; pn[c]++;
  endtask

  // one gate opening at h=0, G windows; ticks are half-ns, samples on even ticks
  task automatic model_single(int G);
    for (int c = 0; c < NCH; c++) begin
      e_n[c] = 0;
      for (int j = 0; j < pn[c]; j++) begin
        int ts, k;
        ts = (pr[c][j] + 1) / 2;
        k  = (ts >= 0) ? ts / 4 : -1;
        if (k >= 0 && k < G && e_n[c] < DEPTH) begin
          e_ts[c][e_n[c]] = ts; e_n[c]++;
        end
      end
    end
  endtask

  // h=0 is the first clk0 rising edge that may see the gate; start at a falling edge
  task automatic run(int h_end);
    @(negedge clk0);
    for (int h = -20; h <= h_end; h++) begin
      gate = (h >= g_on1 && h < g_off1) || (h >= g_on2 && h < g_off2);
      for (int c = 0; c < NCH; c++) begin
        logic lvl;
        lvl = 1'b0;
        for (int j = 0; j < pn[c]; j++)
          if (h >= pr[c][j] && h < pr[c][j] + pw[c][j]) lvl = 1'b1;
        disc[c] = lvl;
      end
      #0.5;
    end
  endtask

  task automatic check_chan(int c, string t_cnt, string t_ts);
    rd_chan = 2'(c);
    for (int i = 0; i < DEPTH; i++) begin
      rd_idx = 2'(i);
      #0.3;
      if (i == 0) check(t_cnt, $sformatf("ch%0d count", c), int'(rd_count), e_n[c]);
      check("R6", $sformatf("ch%0d slot%0d valid", c, i), int'(rd_valid), (i < e_n[c]) ? 1 : 0);
      if (i < e_n[c])
        check(t_ts, $sformatf("ch%0d slot%0d stamp", c, i), int'(rd_ts), e_ts[c][i]);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; gate = 1'b0; disc = '0; rd_chan = '0; rd_idx = '0;
    plan_clear();
    repeat (4) @(posedge clk0);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk0);

    // R1: empty after reset
    for (int c = 0; c < NCH; c++) check_chan(c, "R1", "R1");

    // R2/R5/R8: all four fine codes, per-channel hit counts 2..5
    plan_clear();
    for (int c = 0; c < NCH; c++)
      for (int j = 0; j < c + 2; j++)
        add_pulse(c, 32 * j + 9 + 2 * ((c + j) % 4), 8);
    g_on1 = -4; g_off1 = 8 * 24 - 4;
    model_single(24);
    run(g_off1 + 40);
    for (int c = 0; c < NCH; c++) check_chan(c, (c == 3) ? "R5" : "R8", "R2");

    // R3/R4: level high across opening, last open window, after close, edge before opening
    plan_clear();
    add_pulse(0, -15, 24);
    add_pulse(1, 43, 8);
    add_pulse(2, 57, 8);
    add_pulse(3, -1, 8);
    g_on1 = -4; g_off1 = 8 * 6 - 4;
    model_single(6);
    run(g_off1 + 60);
    check_chan(0, "R3", "R3");
    for (int c = 1; c < NCH; c++) check_chan(c, "R4", "R4");

    // R7: one-cycle gap, clear collides with last-window write of previous gate
    plan_clear();
    add_pulse(0, 33, 8);
    add_pulse(2, 9, 8);
    add_pulse(1, 61, 8);
    g_on1 = -4; g_off1 = 36; g_on2 = 44; g_off2 = 44 + 8 * 4;
    run(g_off2 + 40);
    e_n[0] = 0; e_n[2] = 0; e_n[3] = 0;
    e_n[1] = 1; e_ts[1][0] = 7;
    for (int c = 0; c < NCH; c++) check_chan(c, "R7", "R7");

    summary();
    $finish;
  end

endmodule